// File: doc/BRIEF.md
# Stub Level-2 Cache Controller Register Bank

This block is a memory-mapped register slave that takes the place of a level-2 cache controller in a system that has no real second-level cache. Boot and driver software can probe, configure and run maintenance on it as if a controller were present. There is no cache storage behind it. It holds a one-bit enable control, a full-width auxiliary control word, two latency words and a pair of address-filter bounds. It returns a fixed identification word and a cache-type word. Part of the cache-type word is built from fields of the auxiliary control word, and bits set there stay set.

The bus is APB with zero wait states. There is no back-pressure: `pready` is held high, so every transfer finishes in its access phase. Read data is valid during that access phase, and a write takes effect on the clock edge that ends it. Only the low 12 address bits are decoded. Every maintenance-operation offset reads 0, so software polling for completion always sees the operation as finished. An access to an unmapped offset is never faulted on the bus. It raises a one-clock `err_event` pulse for a monitor to count or log.

Top module: `l2stub_regbank`

## Requirements
- R1: Only `paddr[11:0]` is decoded, so the register window repeats every 4 KiB of address space.
- R2: A read of offset 0x000 returns the identification word (default 0x410000C8). A write to 0x000 is discarded and counts as a bad access.
- R3: A read of offset 0x004 forms v = {aux[19:17], 1'b0, aux[16]}. It ORs (v<<18)|(v<<6) into the stored cache-type word, returns the result and stores it, so set bits accumulate across reads. The stored word resets to parameter `CTYPE_INIT` (default 0x1C100100). A write to 0x004 is discarded and counts as a bad access.
- R4: The control register at 0x100 keeps only bit 0 of a write. Bits 31:1 always read 0.
- R5: Offsets 0x104 (auxiliary control), 0x108 (tag latency), 0x10C (data latency), 0xC00 (filter start) and 0xC04 (filter end) are 32-bit read/write registers.
- R6: Reset sets auxiliary control to 0x02020000. It sets control, both latency words and both filter bounds to 0.
- R7: Any offset from 0x730 to 0x7FF inclusive, aligned or not, reads 0. Writes there are discarded, and no error event is raised.
- R8: Offsets 0xF40, 0xF60 and 0xF80 read 0. Writes to them are discarded, and no error event is raised.
- R9: Every other offset reads 0 and discards writes. Such a bad access drives `err_event` high for exactly the one clock of its access phase.
- R10: `pready` is always 1 and `pslverr` is always 0. Read data is valid in the access phase, and a written value is visible to the very next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW (32) | Byte address; only bits 11:0 decoded |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase of a read |
| pready | output | 1 | Always 1, no wait states |
| pslverr | output | 1 | Always 0, software is never faulted |
| err_event | output | 1 | One-clock pulse on an access to an unmapped offset |

## Verification
The register file is driven with patterns that are all ones, all zeros and distinct per register. These patterns reveal dropped bits, the ctrl bit-0 mask and any crossed register selects. The cache-type word is read with aux values that switch fields on and then back off. This separates a correct sticky OR from a plain recompute and from a register that never updates. Offsets are chosen on both sides of every region edge (0x72C/0x730, 0x7FF/0x800) and with high address bits set. These offsets tell mapped, quiet, maintenance and bad decodes apart, and check that the window aliases. Writes to the read-only words check that a bad write is flagged and does not change any stored value.

// File: rtl/l2stub_pkg.sv
package l2stub_pkg;

  localparam int unsigned DW    = 32;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned NFULL = 5;
  localparam int unsigned SLOT_W = $clog2(NFULL);

  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [3:0] {
    RG_ID, RG_CTYPE, RG_CTRL, RG_AUX, RG_TAG, RG_DATA,
    RG_FSTART, RG_FEND, RG_MAINT, RG_QUIET, RG_BAD
  } region_e;

  localparam off_t OFF_ID     = 12'h000;
  localparam off_t OFF_CTYPE  = 12'h004;
  localparam off_t OFF_CTRL   = 12'h100;
  localparam off_t OFF_AUX    = 12'h104;
  localparam off_t OFF_TAG    = 12'h108;
  localparam off_t OFF_DATA   = 12'h10C;
  localparam off_t OFF_FSTART = 12'hC00;
  localparam off_t OFF_FEND   = 12'hC04;
  localparam off_t OFF_QUIET0 = 12'hF40;
  localparam off_t OFF_QUIET1 = 12'hF60;
  localparam off_t OFF_QUIET2 = 12'hF80;
  localparam off_t MAINT_LO   = 12'h730;
  localparam off_t MAINT_END  = 12'h800;

  localparam slot_t SLOT_AUX    = 3'd0;
  localparam slot_t SLOT_TAG    = 3'd1;
  localparam slot_t SLOT_DATA   = 3'd2;
  localparam slot_t SLOT_FSTART = 3'd3;
  localparam slot_t SLOT_FEND   = 3'd4;

  function automatic logic is_full(region_e r);
    return (r == RG_AUX) || (r == RG_TAG) || (r == RG_DATA) ||
           (r == RG_FSTART) || (r == RG_FEND);
  endfunction

  function automatic slot_t full_slot(region_e r);
    slot_t s;
    case (r)
      RG_TAG:    s = SLOT_TAG;
      RG_DATA:   s = SLOT_DATA;
      RG_FSTART: s = SLOT_FSTART;
      RG_FEND:   s = SLOT_FEND;
      default:   s = SLOT_AUX;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/l2stub_decode.sv
module l2stub_decode
  import l2stub_pkg::*;
(
  input  off_t    off,
  input  logic    is_write,
  output region_e region,
  output logic    bad
);

  logic in_maint;
  assign in_maint = (off >= MAINT_LO) && (off < MAINT_END);

  always_comb begin
    if (in_maint) begin
      region = RG_MAINT;
    end else begin
      case (off)
        OFF_ID:     region = is_write ? RG_BAD : RG_ID;
        OFF_CTYPE:  region = is_write ? RG_BAD : RG_CTYPE;
        OFF_CTRL:   region = RG_CTRL;
        OFF_AUX:    region = RG_AUX;
        OFF_TAG:    region = RG_TAG;
        OFF_DATA:   region = RG_DATA;
        OFF_FSTART: region = RG_FSTART;
        OFF_FEND:   region = RG_FEND;
        OFF_QUIET0,
        OFF_QUIET1,
        OFF_QUIET2: region = RG_QUIET;
        default:    region = RG_BAD;
      endcase
    end
  end

  assign bad = (region == RG_BAD);

endmodule

// File: rtl/l2stub_regs.sv
module l2stub_regs
  import l2stub_pkg::*;
#(
  parameter logic [DW-1:0] AUX_RST = 32'h0202_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_stb,
  input  region_e                   region,
  input  logic [DW-1:0]             wdata,
  output logic                      ctrl_q,
  output logic [NFULL-1:0][DW-1:0]  full_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ctrl_q <= 1'b0;
    else if (wr_stb && region == RG_CTRL)    ctrl_q <= wdata[0];
  end

  for (genvar g = 0; g < NFULL; g++) begin : g_full
    localparam logic [DW-1:0] RST_VAL = (slot_t'(g) == SLOT_AUX) ? AUX_RST : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        full_q[g] <= RST_VAL;
      else if (wr_stb && is_full(region) && full_slot(region) == slot_t'(g))
        full_q[g] <= wdata;
    end
  end

  // R7 R8 R9
  ign_wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !is_full(region) && region != RG_CTRL) |=> ($stable(full_q) && $stable(ctrl_q)));

  // R5
  aux_wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && region == RG_AUX) |=> (full_q[SLOT_AUX] == $past(wdata)));

  // R4
  ctrl_wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && region == RG_CTRL) |=> (ctrl_q == $past(wdata[0])));

endmodule

// File: rtl/l2stub_typeword.sv
module l2stub_typeword
  import l2stub_pkg::*;
#(
  parameter logic [DW-1:0] CTYPE_INIT = 32'h1C10_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic [3:0]    aux_fld,   // aux[19:16]
  output logic [DW-1:0] ctype_view
);

  localparam int unsigned HI_SH = 18;
  localparam int unsigned LO_SH = 6;

  logic [4:0]    v;
  logic [DW-1:0] mask;
  logic [DW-1:0] ctype_q;

  assign v          = {aux_fld[3:1], 1'b0, aux_fld[0]};
  assign mask       = (DW'(v) << HI_SH) | (DW'(v) << LO_SH);
  assign ctype_view = ctype_q | mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctype_q <= CTYPE_INIT;
    else if (rd_stb) ctype_q <= ctype_view;
  end

  // R3
  ctype_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ctype_q & $past(ctype_q)) == $past(ctype_q)));

  // R3
  ctype_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(ctype_q));

endmodule

// File: rtl/l2stub_regbank.sv
module l2stub_regbank
  import l2stub_pkg::*;
#(
  parameter int unsigned   AW         = 32,
  parameter logic [DW-1:0] ID_WORD    = 32'h4100_00C8,
  parameter logic [DW-1:0] AUX_RST    = 32'h0202_0000,
  parameter logic [DW-1:0] CTYPE_INIT = 32'h1C10_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  output logic          pslverr,
  output logic          err_event
);

  off_t    off;
  logic    unused_hi;
  region_e region;
  logic    bad;
  logic    access, rd_stb, wr_stb, ct_rd;
  logic    ctrl_q;
  logic [NFULL-1:0][DW-1:0] full_q;
  logic [DW-1:0] ctype_view;

  assign off       = paddr[OFF_W-1:0];
  assign unused_hi = ^paddr[AW-1:OFF_W];

  assign access = psel && penable;
  assign rd_stb = access && !pwrite;
  assign wr_stb = access && pwrite;
  assign ct_rd  = rd_stb && (region == RG_CTYPE);

  l2stub_decode u_dec (
    .off      (off),
    .is_write (pwrite),
    .region   (region),
    .bad      (bad)
  );

  l2stub_regs #(.AUX_RST(AUX_RST)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .region (region),
    .wdata  (pwdata),
    .ctrl_q (ctrl_q),
    .full_q (full_q)
  );

  l2stub_typeword #(.CTYPE_INIT(CTYPE_INIT)) u_ctype (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_stb     (ct_rd),
    .aux_fld    (full_q[SLOT_AUX][19:16]),
    .ctype_view (ctype_view)
  );

  always_comb begin
    prdata = '0;
    if (rd_stb) begin
      case (region)
        RG_ID:    prdata = ID_WORD;
        RG_CTYPE: prdata = ctype_view;
        RG_CTRL:  prdata = {{(DW-1){1'b0}}, ctrl_q};
        RG_AUX, RG_TAG, RG_DATA, RG_FSTART, RG_FEND:
                  prdata = full_q[full_slot(region)];
        default:  prdata = '0;
      endcase
    end
  end

  assign pready    = 1'b1;
  assign pslverr   = 1'b0;
  assign err_event = access && bad;

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |=> !err_event);

  // R7
  maint_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access && off >= 12'h730 && off < 12'h800) |-> (!err_event && (pwrite || prdata == '0)));

  // R8
  quiet_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access && (off == 12'hF40 || off == 12'hF60 || off == 12'hF80)) |-> !err_event);

  // R2
  id_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && off == 12'h000) |-> (prdata == ID_WORD));

  // R4
  ctrl_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && off == 12'h100) |-> (prdata[31:1] == '0));

endmodule

// File: tb/l2stub_regbank_tb.sv
module l2stub_regbank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0] paddr = '0, pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, err_event;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  l2stub_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .err_event(err_event)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // one APB transfer; err_in = err_event in access phase, err_out = one clock later
  task automatic xfer(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                      output logic [31:0] rd, output logic err_in, output logic err_out);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = wd;
    @(negedge clk);
    penable = 1'b1;
    #1;
    rd = prdata; err_in = err_event;
    chk("R10 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    #1;
    err_out = err_event;
  endtask

  task automatic rd_chk(input string req, input logic [31:0] addr, input logic [31:0] exp,
                        input logic exp_err);
    logic [31:0] d; logic e1, e2;
    xfer(1'b0, addr, '0, d, e1, e2);
    chk(req, d, exp);
    chk({req, " err_event"}, {31'b0, e1}, {31'b0, exp_err});
    if (exp_err) chk({req, " err pulse length"}, {31'b0, e2}, 32'h0);
  endtask

  task automatic wr_do(input string req, input logic [31:0] addr, input logic [31:0] wd,
                       input logic exp_err);
    logic [31:0] d; logic e1, e2;
    xfer(1'b1, addr, wd, d, e1, e2);
    chk({req, " wr err_event"}, {31'b0, e1}, {31'b0, exp_err});
    if (exp_err) chk({req, " wr err pulse length"}, {31'b0, e2}, 32'h0);
  endtask

  task automatic t_reset;
    rd_chk("R2 id", 32'h000, 32'h4100_00C8, 1'b0);
    rd_chk("R6 ctrl reset", 32'h100, 32'h0, 1'b0);
    rd_chk("R6 aux reset", 32'h104, 32'h0202_0000, 1'b0);
    rd_chk("R6 tag reset", 32'h108, 32'h0, 1'b0);
    rd_chk("R6 data reset", 32'h10C, 32'h0, 1'b0);
    rd_chk("R6 fstart reset", 32'hC00, 32'h0, 1'b0);
    rd_chk("R6 fend reset", 32'hC04, 32'h0, 1'b0);
    rd_chk("R3 ctype default", 32'h004, 32'h1C10_0100, 1'b0);
  endtask

  task automatic t_ctrl;
    wr_do("R4", 32'h100, 32'hFFFF_FFFF, 1'b0);
    rd_chk("R4 ctrl keeps bit0", 32'h100, 32'h1, 1'b0);
    wr_do("R4", 32'h100, 32'hFFFF_FFFE, 1'b0);
    rd_chk("R4 ctrl clear", 32'h100, 32'h0, 1'b0);
  endtask

  task automatic t_full;
    wr_do("R5", 32'h104, 32'hA5A5_0001, 1'b0);
    wr_do("R5", 32'h108, 32'h0000_0777, 1'b0);
    wr_do("R5", 32'h10C, 32'hFFFF_FFFF, 1'b0);
    wr_do("R5", 32'hC00, 32'h8000_0000, 1'b0);
    wr_do("R5", 32'hC04, 32'h1234_5678, 1'b0);
    rd_chk("R5 aux", 32'h104, 32'hA5A5_0001, 1'b0);
    rd_chk("R5 tag", 32'h108, 32'h0000_0777, 1'b0);
    rd_chk("R5 data", 32'h10C, 32'hFFFF_FFFF, 1'b0);
    rd_chk("R5 fstart", 32'hC00, 32'h8000_0000, 1'b0);
    rd_chk("R5 fend", 32'hC04, 32'h1234_5678, 1'b0);
    wr_do("R5", 32'h10C, 32'h0, 1'b0);
    rd_chk("R10 write visible next read", 32'h10C, 32'h0, 1'b0);
  endtask

  task automatic t_alias;
    wr_do("R1", 32'hDEAD_5108, 32'h0000_0042, 1'b0);
    rd_chk("R1 alias tag via low offset", 32'h108, 32'h0000_0042, 1'b0);
    rd_chk("R1 alias id high addr", 32'hABCD_E000, 32'h4100_00C8, 1'b0);
  endtask

  task automatic t_ctype;
    wr_do("R3", 32'h104, 32'h0000_0000, 1'b0);
    rd_chk("R3 ctype aux zero", 32'h004, 32'h1C10_0100, 1'b0);
    wr_do("R3", 32'h104, 32'h000F_0000, 1'b0);
    rd_chk("R3 ctype fields on", 32'h004, 32'h1C74_0740, 1'b0);
    wr_do("R3", 32'h104, 32'h0000_0000, 1'b0);
    rd_chk("R3 ctype sticky", 32'h004, 32'h1C74_0740, 1'b0);
    wr_do("R3 write ctype", 32'h004, 32'h0000_0000, 1'b1);
    rd_chk("R3 ctype unchanged by write", 32'h004, 32'h1C74_0740, 1'b0);
    wr_do("R2 write id", 32'h000, 32'h0000_0000, 1'b1);
    rd_chk("R2 id unchanged by write", 32'h000, 32'h4100_00C8, 1'b0);
  endtask

  task automatic t_maint;
    wr_do("R7", 32'h104, 32'h0000_1111, 1'b0);
    rd_chk("R7 maint lo", 32'h730, 32'h0, 1'b0);
    rd_chk("R7 maint hi unaligned", 32'h7FF, 32'h0, 1'b0);
    wr_do("R7", 32'h730, 32'hFFFF_FFFF, 1'b0);
    wr_do("R7", 32'h7F0, 32'hFFFF_FFFF, 1'b0);
    rd_chk("R7 maint after write", 32'h7F0, 32'h0, 1'b0);
    rd_chk("R7 aux untouched", 32'h104, 32'h0000_1111, 1'b0);
    rd_chk("R9 below maint", 32'h72C, 32'h0, 1'b1);
    rd_chk("R9 above maint", 32'h800, 32'h0, 1'b1);
  endtask

  task automatic t_quiet;
    rd_chk("R8 f40", 32'hF40, 32'h0, 1'b0);
    rd_chk("R8 f60", 32'hF60, 32'h0, 1'b0);
    rd_chk("R8 f80", 32'hF80, 32'h0, 1'b0);
    wr_do("R8", 32'hF40, 32'hFFFF_FFFF, 1'b0);
    wr_do("R8", 32'hF80, 32'hFFFF_FFFF, 1'b0);
    rd_chk("R8 f40 after write", 32'hF40, 32'h0, 1'b0);
  endtask

  task automatic t_bad;
    rd_chk("R9 bad read", 32'h200, 32'h0, 1'b1);
    wr_do("R9", 32'hC08, 32'hFFFF_FFFF, 1'b1);
    wr_do("R9", 32'h101, 32'hFFFF_FFFF, 1'b1);
    rd_chk("R9 ctrl untouched", 32'h100, 32'h0, 1'b0);
    rd_chk("R9 fend untouched", 32'hC04, 32'h1234_5678, 1'b0);
    rd_chk("R9 fstart untouched", 32'hC00, 32'h8000_0000, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_full();
    t_alias();
    t_ctype();
    t_maint();
    t_quiet();
    t_bad();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule